// File: doc/BRIEF.md
# Wormhole Crossbar Router Stage

This block is one stage of a wormhole-routed message network. Several input ports share a set of output channels, 14 by default, over a 128-bit data path. The first word of every frame is a routing word. The stage reads that word, removes it from the stream and claims the output channel it names. Every later word of the frame then goes through that channel unchanged and in order. The word marked as the frame close goes through last and releases the channel.

The routing word is not forwarded, so stages can be cascaded by putting one routing word per stage at the head of a frame. The word that follows a routing word is never decoded again by the same stage. Inputs that ask for a busy channel wait with ready held low. When several inputs compete for a free channel, the lowest-numbered input wins. Each input has a sticky flag that records a malformed routing word. A frame with such a word is consumed and discarded through its close word.

Top module: `wormhole_xbar`

## Requirements
- R1: After reset, every `out_valid` bit is 0, every `err_flag` bit is 0, and every `in_ready` bit is 1.
- R2: The routing word is decoded as follows. Bits [3:0] hold the channel index and bit 4 is a parity bit chosen so that the XOR of bits [4:0] is 0. An index from 0 to 13 with correct parity selects that output channel. The routing word itself never appears on any output.
- R3: While a channel is open, `out_valid` of that channel follows `in_valid` of its owner, and `out_data` equals the owner's `in_data`. `in_ready` of the owner follows that channel's `out_ready`. Words arrive in their original order.
- R4: The close word is forwarded with `out_last` = 1. After its handshake, the input expects a new routing word on the next cycle.
- R5: A word that follows the routing word is forwarded unchanged even when it is a valid routing word itself, so a further stage can use it.
- R6: An input whose decoded channel is busy holds `in_ready` at 0 until it is granted. If several waiting inputs name the same free channel, the lowest input index is granted. The channel stays with its owner until the owner's close word is accepted.
- R7: A routing word with a parity error or with index 14 or 15 sets that input's `err_flag`, which stays set until reset. The rest of that frame, through its close word, is accepted with `in_ready` = 1 and nothing is forwarded.
- R8: A routing word that is itself marked as close ends the frame without opening any channel. Its parity and range are still checked under R7.
- R9: A channel released by a close handshake can be granted on the following cycle, and the granted input forwards from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Word present on each input |
| in_data | input | N_IN x DATA_W | Word of each input |
| in_close | input | N_IN | Marks the word as the frame close |
| in_ready | output | N_IN | Input word accepted this cycle when also valid |
| out_valid | output | N_OUT | Word present on each output channel |
| out_data | output | N_OUT x DATA_W | Forwarded word of each channel |
| out_last | output | N_OUT | Copy of the close marker of the forwarded word |
| out_ready | input | N_OUT | Downstream accepts the channel's word |
| err_flag | output | N_IN | Sticky malformed-routing-word flag per input |

## Verification
The hardest state to reach is contention under backpressure. The owner of a channel is stalled by `out_ready` while two or more other inputs have already consumed their routing words and are waiting on that same channel. Each release must then hand the channel to the lowest waiting index with exactly one cycle of turnaround. The stimulus loads all inputs with frames to one channel in the same cycle, and then runs long mixed phases with random gaps in `in_valid` and `out_ready`. A cycle-exact reference model checks every output and every ready bit on each clock. The close order seen on the shared channel is also checked directly.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   // per-input frame state
   typedef enum logic [1:0] {
      ST_ADDR = 2'd0,   // expecting a routing word
      ST_WAIT = 2'd1,   // routing word taken, channel not yet granted
      ST_PASS = 2'd2,   // channel open, forwarding
      ST_DROP = 2'd3    // malformed frame, discarding through close
   } in_state_e;
endpackage

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode #(
   parameter int N_OUT     = 14,
   parameter int IDX_W     = 4,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic [IDX_W:0]   code,
   output logic [IDX_W-1:0] idx,
   output logic             good
);
   localparam logic [IDX_W:0] LIMIT = N_OUT[IDX_W:0];

   logic par_ok;
   logic rng_ok;

   assign idx = code[IDX_W-1:0];

   generate
      if (PARITY_EN) begin : g_par
         assign par_ok = ~(^code);
      end else begin : g_nopar
         assign par_ok = 1'b1;
      end
      if (N_OUT == (1 << IDX_W)) begin : g_full
         assign rng_ok = 1'b1;
      end else begin : g_part
         assign rng_ok = ({1'b0, idx} < LIMIT);
      end
   endgenerate

   assign good = par_ok & rng_ok;
endmodule

// File: rtl/xbar_in_ctrl.sv
module xbar_in_ctrl
   import xbar_pkg::*;
#(
   parameter int N_OUT     = 14,
   parameter int IDX_W     = 4,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_close,
   input  logic [IDX_W:0]   in_code,
   input  logic             grant,
   input  logic             sel_ready,
   output logic             in_ready,
   output logic             req,
   output logic             passing,
   output logic             release_ch,
   output logic [IDX_W-1:0] tgt,
   output logic             err
);
   in_state_e        state;
   logic [IDX_W-1:0] dec_idx;
   logic             dec_good;
   logic             hs;

   xbar_addr_decode #(
      .N_OUT    (N_OUT),
      .IDX_W    (IDX_W),
      .PARITY_EN(PARITY_EN)
   ) u_dec (
      .code(in_code),
      .idx (dec_idx),
      .good(dec_good)
   );

   always_comb begin
      unique case (state)
         ST_ADDR: in_ready = 1'b1;
         ST_WAIT: in_ready = 1'b0;
         ST_PASS: in_ready = sel_ready;
         default: in_ready = 1'b1;
      endcase
   end

   assign hs         = in_valid & in_ready;
   assign req        = (state == ST_WAIT);
   assign passing    = (state == ST_PASS);
   assign release_ch = passing & hs & in_close;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ADDR;
         tgt   <= '0;
         err   <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (in_valid) begin
                  if (!dec_good) err <= 1'b1;
                  if (in_close) begin
                     state <= ST_ADDR;
                  end else if (!dec_good) begin
                     state <= ST_DROP;
                  end else begin
                     tgt   <= dec_idx;
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: if (grant) state <= ST_PASS;
            ST_PASS: if (hs && in_close) state <= ST_ADDR;
            default: if (in_valid && in_close) state <= ST_ADDR;
         endcase
      end
   end

   // error flag never clears once set
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // a waiting input without grant keeps waiting
   p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !grant) |=> (state == ST_WAIT));
   // close handshake returns the input to routing-word decode
   p_close_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      release_ch |=> (state == ST_ADDR));
   // granted input forwards from the next cycle
   p_grant_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && grant) |=> passing);
endmodule

// File: rtl/xbar_out_arb.sv
module xbar_out_arb #(
   parameter int N_IN  = 4,
   parameter int N_OUT = 14,
   parameter int IDX_W = 4,
   parameter int OWN_W = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_IN-1:0]                  req,
   input  logic [N_IN-1:0][IDX_W-1:0]       tgt,
   input  logic [N_IN-1:0]                  release_ch,
   output logic [N_IN-1:0]                  grant,
   output logic [N_OUT-1:0]                 busy,
   output logic [N_OUT-1:0][OWN_W-1:0]      owner
);
   logic [N_OUT-1:0]            win_vld;
   logic [N_OUT-1:0][OWN_W-1:0] win_idx;
   logic [N_OUT-1:0]            rel_o;

   // fixed priority: scan downwards so the lowest index is kept
   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         win_vld[o] = 1'b0;
         win_idx[o] = '0;
         for (int i = N_IN - 1; i >= 0; i--) begin
            if (!busy[o] && req[i] && (tgt[i] == IDX_W'(o))) begin
               win_vld[o] = 1'b1;
               win_idx[o] = OWN_W'(i);
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N_IN; i++) begin
         grant[i] = 1'b0;
         for (int o = 0; o < N_OUT; o++) begin
            if (win_vld[o] && (win_idx[o] == OWN_W'(i))) grant[i] = 1'b1;
         end
      end
   end

   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         rel_o[o] = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            if (busy[o] && (owner[o] == OWN_W'(i)) && release_ch[i]) rel_o[o] = 1'b1;
         end
      end
   end

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy[o]  <= 1'b0;
               owner[o] <= '0;
            end else if (win_vld[o]) begin
               busy[o]  <= 1'b1;
               owner[o] <= win_idx[o];
            end else if (rel_o[o]) begin
               busy[o]  <= 1'b0;
            end
         end

         // channel stays with its owner until the close handshake
         p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[o] && !rel_o[o]) |=> (busy[o] && $stable(owner[o])));
         // release frees the channel on the next cycle
         p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rel_o[o] |=> !busy[o]);
      end
   endgenerate
endmodule

// File: rtl/wormhole_xbar.sv
module wormhole_xbar #(
   parameter int N_IN      = 4,
   parameter int N_OUT     = 14,
   parameter int DATA_W    = 128,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_IN-1:0]              in_valid,
   input  logic [N_IN-1:0][DATA_W-1:0]  in_data,
   input  logic [N_IN-1:0]              in_close,
   output logic [N_IN-1:0]              in_ready,
   output logic [N_OUT-1:0]             out_valid,
   output logic [N_OUT-1:0][DATA_W-1:0] out_data,
   output logic [N_OUT-1:0]             out_last,
   input  logic [N_OUT-1:0]             out_ready,
   output logic [N_IN-1:0]              err_flag
);
   localparam int IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
   localparam int OWN_W = (N_IN > 1) ? $clog2(N_IN) : 1;

   generate
      if (N_IN < 1 || N_OUT < 2) begin : g_bad_count
         $error("wormhole_xbar: need N_IN >= 1 and N_OUT >= 2");
      end
      if (DATA_W < IDX_W + 1) begin : g_bad_width
         $error("wormhole_xbar: DATA_W too narrow for index and parity");
      end
   endgenerate

   logic [N_IN-1:0]             req;
   logic [N_IN-1:0]             passing;
   logic [N_IN-1:0]             release_ch;
   logic [N_IN-1:0]             grant;
   logic [N_IN-1:0]             sel_ready;
   logic [N_IN-1:0][IDX_W-1:0]  tgt;
   logic [N_OUT-1:0]            busy;
   logic [N_OUT-1:0][OWN_W-1:0] owner;

   // ready of the channel each input has opened
   always_comb begin
      for (int i = 0; i < N_IN; i++) begin
         sel_ready[i] = 1'b0;
         for (int o = 0; o < N_OUT; o++) begin
            if (tgt[i] == IDX_W'(o)) sel_ready[i] = out_ready[o];
         end
      end
   end

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         xbar_in_ctrl #(
            .N_OUT    (N_OUT),
            .IDX_W    (IDX_W),
            .PARITY_EN(PARITY_EN)
         ) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_close  (in_close[i]),
            .in_code   (in_data[i][IDX_W:0]),
            .grant     (grant[i]),
            .sel_ready (sel_ready[i]),
            .in_ready  (in_ready[i]),
            .req       (req[i]),
            .passing   (passing[i]),
            .release_ch(release_ch[i]),
            .tgt       (tgt[i]),
            .err       (err_flag[i])
         );
      end
   endgenerate

   xbar_out_arb #(
      .N_IN (N_IN),
      .N_OUT(N_OUT),
      .IDX_W(IDX_W),
      .OWN_W(OWN_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .tgt       (tgt),
      .release_ch(release_ch),
      .grant     (grant),
      .busy      (busy),
      .owner     (owner)
   );

   // output side: each channel shows its owner's word
   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         out_valid[o] = 1'b0;
         out_data[o]  = '0;
         out_last[o]  = 1'b0;
         for (int i = 0; i < N_IN; i++) begin
            if (busy[o] && (owner[o] == OWN_W'(i))) begin
               out_valid[o] = in_valid[i];
               out_data[o]  = in_data[i];
               out_last[o]  = in_close[i];
            end
         end
      end
   end

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_chk
         logic [N_IN-1:0] pass_vec;
         always_comb begin
            for (int i = 0; i < N_IN; i++) begin
               pass_vec[i] = passing[i] && (tgt[i] == IDX_W'(o));
            end
         end
         // at most one input forwards into a channel
         p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pass_vec) <= 1);
         // a channel shows a word only for an input that is forwarding to it
         p_fwd_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (|pass_vec));
      end
   endgenerate
endmodule

// File: tb/sim_wormhole_xbar.sv
`timescale 1ns/1ps
module sim_wormhole_xbar;
   localparam int NI = 4;
   localparam int NO = 14;
   localparam int DW = 128;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [NI-1:0]            in_valid = '0;
   logic [NI-1:0][DW-1:0]    in_data = '0;
   logic [NI-1:0]            in_close = '0;
   logic [NI-1:0]            in_ready;
   logic [NO-1:0]            out_valid;
   logic [NO-1:0][DW-1:0]    out_data;
   logic [NO-1:0]            out_last;
   logic [NO-1:0]            out_ready = '0;
   logic [NI-1:0]            err_flag;

   always #4 clk = ~clk;   // 125 MHz

   wormhole_xbar u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_close(in_close),
      .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_ready(out_ready), .err_flag(err_flag)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit timeout = 1'b0;

   // stimulus queues: bit 128 = close marker
   logic [DW:0] q0[$];
   logic [DW:0] q1[$];
   logic [DW:0] q2[$];
   logic [DW:0] q3[$];

   // reference model
   int mst[NI];
   int mtgt[NI];
   bit merr[NI];
   bit mbusy[NO];
   int mown[NO];

   bit rdy_rand = 1'b0;
   bit gap_rand = 1'b0;
   int exp_fwd = 0;
   int got_fwd = 0;
   int exp_casc = 0;
   int got_casc = 0;
   int seq = 0;
   int ch5_order[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
      end
   endtask

   function automatic int qsize(input int i);
      case (i)
         0: return q0.size();
         1: return q1.size();
         2: return q2.size();
         default: return q3.size();
      endcase
   endfunction

   function automatic logic [DW:0] qhead(input int i);
      case (i)
         0: return q0[0];
         1: return q1[0];
         2: return q2[0];
         default: return q3[0];
      endcase
   endfunction

   task automatic qpush(input int i, input logic [DW:0] w);
      case (i)
         0: q0.push_back(w);
         1: q1.push_back(w);
         2: q2.push_back(w);
         default: q3.push_back(w);
      endcase
   endtask

   task automatic qpop(input int i);
      case (i)
         0: void'(q0.pop_front());
         1: void'(q1.pop_front());
         2: void'(q2.pop_front());
         default: void'(q3.pop_front());
      endcase
   endtask

   function automatic logic [DW-1:0] mk_addr(input int idx, input bit badpar);
      logic [DW-1:0] w;
      w = {$urandom, $urandom, $urandom, $urandom};
      w[3:0] = idx[3:0];
      w[4] = (^idx[3:0]) ^ badpar;
      return w;
   endfunction

   // frame: routing word then nw data words, last one closes
   task automatic add_frame(input int i, input int idx, input bit badpar,
                            input int nw, input bit addr_close);
      logic [DW-1:0] w;
      bit good;
      good = !badpar && idx < NO;
      qpush(i, {addr_close, mk_addr(idx, badpar)});
      if (addr_close) return;
      for (int k = 0; k < nw; k++) begin
         seq++;
         if (k == 0 && (seq % 3 == 0)) begin
            w = mk_addr($urandom % NO, 1'b0);   // cascade routing word
            w[127:120] = 8'hA5;
            if (good) exp_casc++;
         end else begin
            w = {$urandom, $urandom, $urandom, $urandom};
            w[127:120] = 8'h00;
         end
         w[119:112] = 8'(i);
         qpush(i, {(k == nw - 1), w});
      end
      if (good) exp_fwd += nw;
   endtask

   task automatic step();
      logic [DW:0] h;
      bit exp_rdy[NI];
      bit ev;
      int gwin[NO];
      int idx;
      bit good;
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
         if (qsize(i) > 0 && (!gap_rand || ($urandom % 5) != 0)) begin
            h = qhead(i);
            in_valid[i] = 1'b1;
            in_data[i]  = h[DW-1:0];
            in_close[i] = h[DW];
         end else begin
            in_valid[i] = 1'b0;
            in_data[i]  = '0;
            in_close[i] = 1'b0;
         end
      end
      for (int o = 0; o < NO; o++) out_ready[o] = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      #1;
      // expected outputs
      for (int i = 0; i < NI; i++) begin
         case (mst[i])
            1: exp_rdy[i] = 1'b0;
            2: exp_rdy[i] = out_ready[mtgt[i]];
            default: exp_rdy[i] = 1'b1;
         endcase
         chk(in_ready[i] == exp_rdy[i], "R6", $sformatf("in_ready[%0d]", i),
             DW'(in_ready[i]), DW'(exp_rdy[i]));
         chk(err_flag[i] == merr[i], "R7", $sformatf("err_flag[%0d]", i),
             DW'(err_flag[i]), DW'(merr[i]));
      end
      for (int o = 0; o < NO; o++) begin
         ev = mbusy[o] && in_valid[mown[o]];
         chk(out_valid[o] == ev, "R3/R9", $sformatf("out_valid[%0d]", o),
             DW'(out_valid[o]), DW'(ev));
         if (ev) begin
            chk(out_data[o] == in_data[mown[o]], "R3", $sformatf("out_data[%0d]", o),
                out_data[o], in_data[mown[o]]);
            chk(out_last[o] == in_close[mown[o]], "R4", $sformatf("out_last[%0d]", o),
                DW'(out_last[o]), DW'(in_close[mown[o]]));
         end
         if (out_valid[o] && out_ready[o]) begin
            got_fwd++;
            if (out_data[o][127:120] == 8'hA5) got_casc++;
            if (o == 5 && out_last[o]) ch5_order.push_back(int'(out_data[o][119:112]));
         end
      end
      // arbitration on pre-update state
      for (int o = 0; o < NO; o++) begin
         gwin[o] = -1;
         if (!mbusy[o])
            for (int i = 0; i < NI; i++)
               if (mst[i] == 1 && mtgt[i] == o && gwin[o] < 0) gwin[o] = i;
      end
      for (int i = 0; i < NI; i++) begin
         case (mst[i])
            0: if (in_valid[i]) begin
                  idx  = int'(in_data[i][3:0]);
                  good = (^in_data[i][4:0]) == 1'b0 && idx < NO;
                  if (!good) merr[i] = 1'b1;
                  if (!in_close[i]) begin
                     if (!good) mst[i] = 3;
                     else begin mtgt[i] = idx; mst[i] = 1; end
                  end
               end
            1: if (gwin[mtgt[i]] == i) mst[i] = 2;
            2: if (in_valid[i] && exp_rdy[i] && in_close[i]) begin
                  mst[i] = 0;
                  mbusy[mtgt[i]] = 1'b0;
               end
            default: if (in_valid[i] && in_close[i]) mst[i] = 0;
         endcase
         if (in_valid[i] && exp_rdy[i]) qpop(i);
      end
      for (int o = 0; o < NO; o++)
         if (gwin[o] >= 0) begin mbusy[o] = 1'b1; mown[o] = gwin[o]; end
      cyc++;
   endtask

   task automatic drain();
      bit busy_any;
      busy_any = 1'b1;
      while (busy_any && !timeout) begin
         step();
         busy_any = 1'b0;
         for (int i = 0; i < NI; i++)
            if (qsize(i) > 0 || mst[i] != 0) busy_any = 1'b1;
         if (cyc > 150000) begin
            timeout = 1'b1;
            chk(1'b0, "watchdog", "run hung", DW'(cyc), '0);
         end
      end
      for (int k = 0; k < 3; k++) step();
   endtask

   initial begin
      for (int i = 0; i < NI; i++) begin mst[i] = 0; mtgt[i] = 0; merr[i] = 0; end
      for (int o = 0; o < NO; o++) begin mbusy[o] = 0; mown[o] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == '0, "R1", "out_valid after reset", DW'(out_valid), '0);
      chk(err_flag == '0, "R1", "err_flag after reset", DW'(err_flag), '0);
      chk(in_ready == '1, "R1", "in_ready after reset", DW'(in_ready), DW'(4'hF));

      // distinct channels per input
      for (int r = 0; r < 3; r++)
         for (int i = 0; i < NI; i++) add_frame(i, (i * 3 + r) % NO, 1'b0, 2 + r, 1'b0);
      drain();

      // contention: all inputs to channel 5 at once, with backpressure
      rdy_rand = 1'b1;
      ch5_order.delete();
      for (int i = 0; i < NI; i++) add_frame(i, 5, 1'b0, 4, 1'b0);
      drain();
      chk(ch5_order.size() == 4, "R6", "frames closed on channel 5",
          DW'(ch5_order.size()), DW'(4));
      for (int k = 0; k < 4 && k < ch5_order.size(); k++)
         chk(ch5_order[k] == k, "R6", $sformatf("priority order slot %0d", k),
             DW'(ch5_order[k]), DW'(k));
      rdy_rand = 1'b0;

      // malformed routing words and routing word carrying close
      add_frame(0, 3, 1'b1, 3, 1'b0);
      add_frame(1, 14, 1'b0, 2, 1'b0);
      add_frame(2, 15, 1'b0, 2, 1'b0);
      add_frame(3, 7, 1'b0, 0, 1'b1);
      drain();
      chk(err_flag == 4'b0111, "R7/R8", "err_flag after bad frames",
          DW'(err_flag), DW'(4'b0111));
      chk(out_valid == '0, "R8", "no channel opened by close routing word",
          DW'(out_valid), '0);
      add_frame(3, 2, 1'b1, 0, 1'b1);
      drain();
      chk(err_flag == 4'b1111, "R8", "bad close routing word flags error",
          DW'(err_flag), DW'(4'b1111));

      // random mix with gaps and backpressure
      rdy_rand = 1'b1;
      gap_rand = 1'b1;
      for (int n = 0; n < 160; n++)
         add_frame($urandom % NI, ($urandom % 9 == 0) ? 14 + ($urandom % 2) : ($urandom % 6),
                   ($urandom % 11 == 0), 1 + ($urandom % 5), ($urandom % 13 == 0));
      drain();

      chk(got_fwd == exp_fwd, "R2", "forwarded word count (routing words removed)",
          DW'(got_fwd), DW'(exp_fwd));
      chk(got_casc == exp_casc, "R5", "cascade routing words forwarded",
          DW'(got_casc), DW'(exp_casc));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule